// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block decides which ready instructions leave the scheduler each cycle in an out-of-order core. Every ready instruction belongs to one operation class and carries a sequence number and a thread number. Each class has its own small ready queue, and each queue feeds one kind of functional unit. Every cycle the selector ranks the non-empty queues by the age of their oldest entry. It then walks that ranking from the oldest down and grants instructions to the execute port, up to a fixed issue width.

A class whose functional unit is not free this cycle is passed over and a busy event is recorded for it. The walk then carries on with the next-oldest class in the same cycle. A flush input removes the entries of one thread that are younger than a given sequence number. Producers load each class queue through a valid/ready handshake.

Issue decisions depend only on the registered queue contents and the current `fu_free` and `flush_valid` inputs. An entry accepted at a clock edge can therefore issue in the very next cycle. Granted entries leave their queue at the edge that closes the cycle.

Top module: `iss_issue_sel`

## Requirements
- R1: After reset every queue is empty: `iss_valid` is 0, every `enq_ready` bit is 1, `busy_evt` is 0 and every `busy_cnt` field is 0.
- R2: An entry is accepted at a rising edge when `enq_valid[c]` and `enq_ready[c]` are both 1. `enq_ready[c]` is 0 while class c already holds 4 entries or while `flush_valid` is 1.
- R3: Within one class, the entry with the smallest sequence number is the one offered for issue. Sequence numbers are compared as unsigned magnitudes, with no wraparound.
- R4: Classes are considered from the oldest head to the youngest. A tie between heads goes to the lower class index. Issue slot 0 carries the oldest granted entry, and each later slot carries a younger one.
- R5: At most 2 grants are made per cycle, and at most one per class.
- R6: A class is granted only when its `fu_free` bit is 1. A class that is not free is skipped, and the next-oldest class is considered in the same cycle.
- R7: A busy event is raised on `busy_evt[c]` in any cycle where all of these hold: class c is non-empty, its unit is not free, and fewer than 2 grants were made to older classes. Each busy event adds 1 to the 8-bit field `busy_cnt[c]` (wrapping) at the next edge.
- R8: While `flush_valid` is 1, nothing is issued, no busy event is raised and nothing is enqueued. At the edge, every entry whose thread equals `flush_tid` and whose sequence number is strictly greater than `flush_seq` is removed. Entries of the other thread are kept, and so is an entry with a sequence number equal to `flush_seq`.
- R9: Issue slots are filled from slot 0 upward. Each valid slot reports the entry's sequence number, thread and class index. Each granted entry is removed from its queue at the edge ending the cycle.
- R10: An entry accepted at an edge can be issued in the next cycle, with `iss_*` outputs derived combinationally from queue state and `fu_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | NUM_CLS | Per-class enqueue request |
| enq_ready | output | NUM_CLS | Per-class enqueue acceptance |
| enq_seq | input | NUM_CLS x SEQ_W | Sequence number for each class's enqueue |
| enq_tid | input | NUM_CLS x TID_W | Thread number for each class's enqueue |
| fu_free | input | NUM_CLS | Functional unit of class c can take an instruction this cycle |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | TID_W | Thread being flushed |
| flush_seq | input | SEQ_W | Entries younger than this are removed |
| iss_valid | output | ISSUE_W | Issue slot holds a granted instruction |
| iss_seq | output | ISSUE_W x SEQ_W | Sequence number in each slot |
| iss_tid | output | ISSUE_W x TID_W | Thread number in each slot |
| iss_cls | output | ISSUE_W x CLS_W | Class index in each slot |
| busy_evt | output | NUM_CLS | Class was passed over this cycle because its unit was busy |
| busy_cnt | output | NUM_CLS x CNT_W | Wrapping count of busy events per class |

## Verification
The hardest situation to reach is a cycle where the busy class sits between two granted classes in age order. In that cycle the walk has to skip one class and still fill the second slot, and younger busy classes beyond the width must stay silent. Random runs keep all four queues close to full and make each unit free about two thirds of the time, so such mixes of busy and free classes occur often. Directed phases add three specific cases: a cross-class tie on the head sequence number, a flush whose bound equals a queued sequence number, and a full queue that refuses a fifth entry.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
    parameter int unsigned SEQ_W = 8;
    parameter int unsigned TID_W = 1;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        logic vld;
        seq_t seq;
        tid_t tid;
    } ent_t;
endpackage

// File: rtl/iss_cls_queue.sv
module iss_cls_queue
    import iss_sel_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enq_valid,
    input  seq_t enq_seq,
    input  tid_t enq_tid,
    output logic enq_ready,
    input  logic flush_valid,
    input  tid_t flush_tid,
    input  seq_t flush_seq,
    input  logic pop,
    output logic head_vld,
    output seq_t head_seq,
    output tid_t head_tid
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        ent_t [DEPTH-1:0] slot;
    } qst_t;

    qst_t             st_q, st_d;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    // locate the oldest live entry and the lowest free slot
    always_comb begin
        full     = 1'b1;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.slot[i].vld) begin
                full     = 1'b0;
                free_idx = IDX_W'(i);
            end
        end
        head_vld = 1'b0;
        head_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.slot[i].vld &&
                (!head_vld || (st_q.slot[i].seq < st_q.slot[head_idx].seq))) begin
                head_vld = 1'b1;
                head_idx = IDX_W'(i);
            end
        end
    end

    assign head_seq  = st_q.slot[head_idx].seq;
    assign head_tid  = st_q.slot[head_idx].tid;
    assign enq_ready = !full && !flush_valid;

    always_comb begin
        st_d = st_q;
        if (flush_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.slot[i].vld && (st_q.slot[i].tid == flush_tid) &&
                    (st_q.slot[i].seq > flush_seq)) begin
                    st_d.slot[i].vld = 1'b0;
                end
            end
        end else begin
            if (pop && head_vld) begin
                st_d.slot[head_idx].vld = 1'b0;
            end
            if (enq_valid && enq_ready) begin
                st_d.slot[free_idx].vld = 1'b1;
                st_d.slot[free_idx].seq = enq_seq;
                st_d.slot[free_idx].tid = enq_tid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/iss_age_pick.sv
module iss_age_pick
    import iss_sel_pkg::*;
#(
    parameter int unsigned NUM_CLS = 4,
    parameter int unsigned ISSUE_W = 2,
    localparam int unsigned CLS_W  = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
    input  logic                            en,
    input  logic [NUM_CLS-1:0]              head_vld,
    input  seq_t [NUM_CLS-1:0]              head_seq,
    input  logic [NUM_CLS-1:0]              fu_free,
    output logic [NUM_CLS-1:0]              grant,
    output logic [NUM_CLS-1:0]              busy,
    output logic [ISSUE_W-1:0]              slot_vld,
    output logic [ISSUE_W-1:0][CLS_W-1:0]   slot_cls
);
    localparam int unsigned RK_W = $clog2(NUM_CLS + 1);
    localparam int unsigned CN_W = $clog2(ISSUE_W + 1);
    localparam int unsigned SL_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

    logic [NUM_CLS-1:0][RK_W-1:0] rank;
    logic [CN_W-1:0]              n_granted;

    // age rank of each class head among the non-empty classes
    always_comb begin
        for (int c = 0; c < NUM_CLS; c++) begin
            rank[c] = '0;
            for (int d = 0; d < NUM_CLS; d++) begin
                if (head_vld[d] && (d != c) &&
                    ((head_seq[d] < head_seq[c]) ||
                     ((head_seq[d] == head_seq[c]) && (d < c)))) begin
                    rank[c] = rank[c] + 1'b1;
                end
            end
        end
    end

    // walk classes oldest first, granting up to the issue width
    always_comb begin
        grant     = '0;
        busy      = '0;
        slot_vld  = '0;
        slot_cls  = '0;
        n_granted = '0;
        if (en) begin
            for (int p = 0; p < NUM_CLS; p++) begin
                for (int c = 0; c < NUM_CLS; c++) begin
                    if (head_vld[c] && (rank[c] == RK_W'(p)) &&
                        (n_granted < CN_W'(ISSUE_W))) begin
                        if (fu_free[c]) begin
                            grant[c]                        = 1'b1;
                            slot_vld[n_granted[SL_W-1:0]]   = 1'b1;
                            slot_cls[n_granted[SL_W-1:0]]   = CLS_W'(c);
                            n_granted                       = n_granted + 1'b1;
                        end else begin
                            busy[c] = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/iss_issue_sel.sv
module iss_issue_sel
    import iss_sel_pkg::*;
#(
    parameter int unsigned NUM_CLS = 4,
    parameter int unsigned QDEPTH  = 4,
    parameter int unsigned ISSUE_W = 2,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned CLS_W  = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CLS-1:0]                enq_valid,
    output logic [NUM_CLS-1:0]                enq_ready,
    input  logic [NUM_CLS-1:0][SEQ_W-1:0]     enq_seq,
    input  logic [NUM_CLS-1:0][TID_W-1:0]     enq_tid,
    input  logic [NUM_CLS-1:0]                fu_free,
    input  logic                              flush_valid,
    input  logic [TID_W-1:0]                  flush_tid,
    input  logic [SEQ_W-1:0]                  flush_seq,
    output logic [ISSUE_W-1:0]                iss_valid,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq,
    output logic [ISSUE_W-1:0][TID_W-1:0]     iss_tid,
    output logic [ISSUE_W-1:0][CLS_W-1:0]     iss_cls,
    output logic [NUM_CLS-1:0]                busy_evt,
    output logic [NUM_CLS-1:0][CNT_W-1:0]     busy_cnt
);
    typedef struct packed {
        logic [NUM_CLS-1:0][CNT_W-1:0] cnt;
    } bst_t;

    logic [NUM_CLS-1:0]        head_vld;
    seq_t [NUM_CLS-1:0]        head_seq;
    tid_t [NUM_CLS-1:0]        head_tid;
    logic [NUM_CLS-1:0]        grant;
    logic [NUM_CLS-1:0]        busy;
    logic [ISSUE_W-1:0]        slot_vld;
    logic [ISSUE_W-1:0][CLS_W-1:0] slot_cls;
    bst_t                      bst_q, bst_d;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        iss_cls_queue #(.DEPTH(QDEPTH)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .enq_valid  (enq_valid[c]),
            .enq_seq    (enq_seq[c]),
            .enq_tid    (enq_tid[c]),
            .enq_ready  (enq_ready[c]),
            .flush_valid(flush_valid),
            .flush_tid  (flush_tid),
            .flush_seq  (flush_seq),
            .pop        (grant[c]),
            .head_vld   (head_vld[c]),
            .head_seq   (head_seq[c]),
            .head_tid   (head_tid[c])
        );
    end

    iss_age_pick #(.NUM_CLS(NUM_CLS), .ISSUE_W(ISSUE_W)) u_pick (
        .en      (!flush_valid),
        .head_vld(head_vld),
        .head_seq(head_seq),
        .fu_free (fu_free),
        .grant   (grant),
        .busy    (busy),
        .slot_vld(slot_vld),
        .slot_cls(slot_cls)
    );

    // route the granted heads onto the execute slots
    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            iss_valid[s] = slot_vld[s];
            iss_cls[s]   = slot_cls[s];
            iss_seq[s]   = slot_vld[s] ? head_seq[slot_cls[s]] : '0;
            iss_tid[s]   = slot_vld[s] ? head_tid[slot_cls[s]] : '0;
        end
    end

    assign busy_evt = busy;
    assign busy_cnt = bst_q.cnt;

    always_comb begin
        bst_d = bst_q;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (busy[c]) begin
                bst_d.cnt[c] = bst_q.cnt[c] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst_q <= '0;
        end else begin
            bst_q <= bst_d;
        end
    end
endmodule

// File: rtl/iss_sel_chk.sv
module iss_sel_chk
    import iss_sel_pkg::*;
#(
    parameter int unsigned NUM_CLS = 4,
    parameter int unsigned ISSUE_W = 2,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned CLS_W  = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_CLS-1:0]                enq_ready,
    input logic [NUM_CLS-1:0]                fu_free,
    input logic                              flush_valid,
    input logic [ISSUE_W-1:0]                iss_valid,
    input logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq,
    input logic [ISSUE_W-1:0][CLS_W-1:0]     iss_cls,
    input logic [NUM_CLS-1:0]                busy_evt,
    input logic [NUM_CLS-1:0][CNT_W-1:0]     busy_cnt
);
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ((iss_valid == '0) && (enq_ready == '0) && (busy_evt == '0))); // R8

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        AST_FU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> fu_free[iss_cls[s]]); // R6
        if (s > 0) begin : g_ord
            AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[s] |-> (iss_valid[s-1] && (iss_seq[s-1] <= iss_seq[s]) &&
                                  (iss_cls[s-1] != iss_cls[s]))); // R4
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        AST_BUSY_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            busy_evt[c] |-> !fu_free[c]); // R7
        AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            busy_evt[c] |=> (busy_cnt[c] == CNT_W'($past(busy_cnt[c]) + 1'b1))); // R7
        AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_evt[c] |=> $stable(busy_cnt[c])); // R7
    end
endmodule

bind iss_issue_sel iss_sel_chk #(
    .NUM_CLS(NUM_CLS),
    .ISSUE_W(ISSUE_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_ready  (enq_ready),
    .fu_free    (fu_free),
    .flush_valid(flush_valid),
    .iss_valid  (iss_valid),
    .iss_seq    (iss_seq),
    .iss_cls    (iss_cls),
    .busy_evt   (busy_evt),
    .busy_cnt   (busy_cnt)
);

// File: tb/iss_issue_sel_tb.sv
module iss_issue_sel_tb;
    localparam int NC = 4;
    localparam int QD = 4;
    localparam int IW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NC-1:0]      enq_valid = '0;
    logic [NC-1:0]      enq_ready;
    logic [NC-1:0][7:0] enq_seq = '0;
    logic [NC-1:0][0:0] enq_tid = '0;
    logic [NC-1:0]      fu_free = '0;
    logic               flush_valid = 1'b0;
    logic [0:0]         flush_tid = '0;
    logic [7:0]         flush_seq = '0;
    logic [IW-1:0]      iss_valid;
    logic [IW-1:0][7:0] iss_seq;
    logic [IW-1:0][0:0] iss_tid;
    logic [IW-1:0][1:0] iss_cls;
    logic [NC-1:0]      busy_evt;
    logic [NC-1:0][7:0] busy_cnt;

    always #2 clk = ~clk;

    iss_issue_sel u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_seq(enq_seq), .enq_tid(enq_tid),
        .fu_free(fu_free),
        .flush_valid(flush_valid), .flush_tid(flush_tid), .flush_seq(flush_seq),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_tid(iss_tid), .iss_cls(iss_cls),
        .busy_evt(busy_evt), .busy_cnt(busy_cnt)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference: one queue of (seq, tid) per class
    int m_seq [NC][$];
    int m_tid [NC][$];
    int m_cnt [NC];
    bit inuse [256];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int head_pos(int c);
        int b = 0;
        for (int i = 1; i < m_seq[c].size(); i++)
            if (m_seq[c][i] < m_seq[c][b]) b = i;
        return b;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < NC; c++) begin
            m_seq[c].delete();
            m_tid[c].delete();
            m_cnt[c] = 0;
        end
        for (int i = 0; i < 256; i++) inuse[i] = 0;
    endtask

    // compare this cycle against the model, then advance the model
    task automatic cycle();
        int exp_rdy [NC];
        int exp_busy [NC];
        int exp_gnt [NC];
        int sv [IW];
        int ss [IW];
        int st [IW];
        int sc [IW];
        bit used [NC];
        int ng;
        #1;
        for (int c = 0; c < NC; c++) begin
            exp_rdy[c]  = (!flush_valid && m_seq[c].size() < QD) ? 1 : 0;
            exp_busy[c] = 0;
            exp_gnt[c]  = 0;
            used[c]     = 0;
        end
        for (int s = 0; s < IW; s++) begin sv[s] = 0; ss[s] = 0; st[s] = 0; sc[s] = 0; end
        ng = 0;
        if (!flush_valid) begin
            for (int k = 0; k < NC; k++) begin
                int best = -1;
                for (int c = 0; c < NC; c++) begin
                    if (!used[c] && m_seq[c].size() > 0) begin
                        if (best < 0 || m_seq[c][head_pos(c)] < m_seq[best][head_pos(best)])
                            best = c;
                    end
                end
                if (best >= 0 && ng < IW) begin
                    used[best] = 1;
                    if (fu_free[best]) begin
                        exp_gnt[best] = 1;
                        sv[ng] = 1;
                        ss[ng] = m_seq[best][head_pos(best)];
                        st[ng] = m_tid[best][head_pos(best)];
                        sc[ng] = best;
                        ng++;
                    end else begin
                        exp_busy[best] = 1;
                    end
                end
            end
        end
        for (int c = 0; c < NC; c++) begin
            chk("R2 enq_ready", int'(enq_ready[c]), exp_rdy[c]);
            chk("R7 busy_evt", int'(busy_evt[c]), exp_busy[c]);
            chk("R7 busy_cnt", int'(busy_cnt[c]), m_cnt[c]);
        end
        for (int s = 0; s < IW; s++) begin
            chk("R5 R6 iss_valid", int'(iss_valid[s]), sv[s]);
            if (sv[s] != 0) begin
                chk("R3 R4 iss_seq", int'(iss_seq[s]), ss[s]);
                chk("R9 iss_tid", int'(iss_tid[s]), st[s]);
                chk("R4 iss_cls", int'(iss_cls[s]), sc[s]);
            end
        end
        // model update at the edge
        for (int c = 0; c < NC; c++) begin
            if (exp_busy[c] != 0) m_cnt[c] = (m_cnt[c] + 1) % 256;
            if (flush_valid) begin
                for (int i = m_seq[c].size() - 1; i >= 0; i--) begin
                    if (m_tid[c][i] == int'(flush_tid) && m_seq[c][i] > int'(flush_seq)) begin
                        inuse[m_seq[c][i]] = 0;
                        m_seq[c].delete(i);
                        m_tid[c].delete(i);
                    end
                end
            end else begin
                if (exp_gnt[c] != 0) begin
                    int h = head_pos(c);
                    inuse[m_seq[c][h]] = 0;
                    m_seq[c].delete(h);
                    m_tid[c].delete(h);
                end
            end
            if (enq_valid[c]) begin
                if (exp_rdy[c] != 0) begin
                    m_seq[c].push_back(int'(enq_seq[c]));
                    m_tid[c].push_back(int'(enq_tid[c]));
                end else begin
                    inuse[enq_seq[c]] = 0;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        enq_valid = '0; flush_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        fu_free = '0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        #1;
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 enq_ready", int'(enq_ready), 15);
        chk("R1 busy_evt", int'(busy_evt), 0);
        chk("R1 busy_cnt", int'(busy_cnt), 0);
        @(negedge clk);

        // R2: fill class 1 with units busy, fifth entry refused; R7 busy counted
        fu_free = '0;
        for (int i = 0; i < 5; i++) begin
            enq_valid = 4'b0010; enq_seq[1] = 8'(40 - i * 5); enq_tid[1] = 1'(i);
            cycle();
        end
        idle();
        cycle();
        // R3: drain class 1, smallest first, one per cycle (R5)
        fu_free = 4'b1111;
        repeat (5) cycle();

        // R4: tie across classes 0 and 2, lower class wins slot 0
        enq_valid = 4'b0101; enq_seq[0] = 8'd10; enq_seq[2] = 8'd10;
        enq_tid[0] = 1'b0; enq_tid[2] = 1'b1;
        fu_free = '0;
        cycle();
        idle();
        fu_free = 4'b1111;
        cycle();
        cycle();

        // R6: oldest class busy is skipped, next two classes issue; R10 next-cycle issue
        enq_valid = 4'b1111;
        enq_seq[0] = 8'd3; enq_seq[1] = 8'd7; enq_seq[2] = 8'd5; enq_seq[3] = 8'd9;
        enq_tid = '0;
        cycle();
        idle();
        fu_free = 4'b1110;
        cycle();
        fu_free = 4'b0000;
        cycle();
        fu_free = 4'b1111;
        repeat (3) cycle();

        // R8: flush with bound equal to a queued seq keeps that entry and the other thread
        enq_valid = 4'b1001; enq_seq[3] = 8'd5; enq_tid[3] = 1'b0;
        enq_seq[0] = 8'd30; enq_tid[0] = 1'b1;
        fu_free = '0;
        cycle();
        enq_valid = 4'b1000; enq_seq[3] = 8'd9; cycle();
        enq_valid = 4'b1000; enq_seq[3] = 8'd12; cycle();
        idle();
        flush_valid = 1'b1; flush_tid = 1'b0; flush_seq = 8'd9;
        enq_valid = 4'b0100; enq_seq[2] = 8'd50;
        cycle();
        idle();
        fu_free = 4'b1111;
        repeat (4) cycle();

        // random traffic
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            idle();
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(0, 1) == 1) begin
                    int v;
                    do v = $urandom_range(0, 255); while (inuse[v]);
                    inuse[v] = 1;
                    enq_valid[c] = 1'b1;
                    enq_seq[c] = 8'(v);
                    enq_tid[c] = 1'($urandom_range(0, 1));
                end
                fu_free[c] = ($urandom_range(0, 2) != 0);
            end
            if ($urandom_range(0, 31) == 0) begin
                flush_valid = 1'b1;
                flush_tid = 1'($urandom_range(0, 1));
                flush_seq = 8'($urandom_range(0, 255));
            end
            cycle();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule